// File: doc/BRIEF.md
# Address-Space Tag Recency Stack

This block sits beside a TLB and lets each TLB entry carry a 3-bit tag in place of the full origin of an address-space translation table. It keeps up to seven recently used table origins. On every address-space switch, the incoming origin is searched against the stored ones.

On a match, the stored tag is handed back and that entry becomes the most recent. When there is no match and a slot is still empty, the next unused slot is claimed. When there is no match and all seven slots are taken, the least recently used slot is reclaimed. In that case the block emits a one-cycle purge strobe carrying the reclaimed tag, so the TLB can invalidate every entry that still holds it. The reclaimed tag is then given to the new origin.

The TLB stores the tag now on `cur_tag` with each entry it fills. Tag code zero is never handed out, so a TLB entry whose tag is zero is invalid.

Top module: `asid_tag_stack`

## Requirements
- R1: While reset is active, and after it is released, `cur_tag` is 3'b000 and both `lookup_hit` and `purge_valid` are low until the first switch.
- R2: Tag code 3'b000 means invalid and is never issued. After any switch, `cur_tag` holds a code from 1 to 7.
- R3: After reset, the first seven distinct origins presented receive tags 1, 2, 3, 4, 5, 6, 7 in that order, with no purge.
- R4: A switch to an origin that is already stored returns that origin's existing tag and raises `lookup_hit`, with no purge.
- R5: A hit makes that entry the most recently used, so it is evicted last among the stored origins.
- R6: A miss with all seven slots occupied evicts the least recently used slot. `purge_valid` rises with `purge_tag` equal to the evicted tag, and the new origin takes that same tag on `cur_tag`.
- R7: `cur_tag` does not change in any cycle without an accepted switch.
- R8: `purge_valid` and `lookup_hit` are pulses that describe only the switch accepted on the previous edge. Both are low after an edge with no switch, and `purge_tag` is 3'b000 whenever `purge_valid` is low.
- R9: A switch is accepted on every clock edge where `switch_valid` is high. Its results appear on the outputs after that same edge, so back-to-back switches are handled one per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| switch_valid | input | 1 | Address-space switch request for this cycle |
| switch_origin | input | OW | Table origin of the address space being entered |
| cur_tag | output | 3 | Tag of the current address space (0 = none) |
| lookup_hit | output | 1 | Last switch found its origin already stored |
| purge_valid | output | 1 | One-cycle strobe: invalidate TLB entries with `purge_tag` |
| purge_tag | output | 3 | Tag being reclaimed; 0 when no purge |

## Verification
The assertions take for granted that the origins stored at one time are all distinct. The block only stores an origin after a missed search, so this holds for any input sequence, and a match can therefore never be ambiguous. The assertions also treat `switch_valid` as meaningful on every edge, with no handshake. The stimulus drives inputs only on the falling edge and holds them steady across each rising edge. It reuses origins only in ways that create hits or deliberate re-entry of an origin that was evicted earlier.

// File: rtl/asid_tag_stack.sv
module asid_tag_stack #(
  parameter int OW    = 24,
  parameter int DEPTH = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          switch_valid,
  input  logic [OW-1:0] switch_origin,
  output logic [2:0]    cur_tag,
  output logic          lookup_hit,
  output logic          purge_valid,
  output logic [2:0]    purge_tag
);
  localparam int TW = $clog2(DEPTH + 1);
  localparam int PW = $clog2(DEPTH);

  logic [TW-1:0] order [DEPTH];
  logic [OW-1:0] org   [DEPTH];
  logic [TW-1:0] fill_cnt;
  logic [DEPTH-1:0] pos_match;
  logic          hit_any;
  logic [PW-1:0] hit_pos;
  logic [PW-1:0] mv_pos;
  logic [TW-1:0] mv_slot;
  logic          full;

  for (genvar i = 0; i < DEPTH; i++) begin : g_cmp
    assign pos_match[i] = (TW'(i) < fill_cnt) && (org[order[i] - TW'(1)] == switch_origin);
  end

  always_comb begin
    hit_pos = '0;
    for (int i = DEPTH - 1; i >= 0; i--)
      if (pos_match[i]) hit_pos = PW'(i);
  end

  assign hit_any = |pos_match;
  assign full    = (fill_cnt == TW'(DEPTH));
  assign mv_pos  = hit_any ? hit_pos : (full ? PW'(DEPTH - 1) : PW'(fill_cnt));
  assign mv_slot = order[mv_pos];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) order[i] <= TW'(i + 1);
      fill_cnt    <= '0;
      cur_tag     <= 3'd0;
      lookup_hit  <= 1'b0;
      purge_valid <= 1'b0;
      purge_tag   <= 3'd0;
    end else if (switch_valid) begin
      order[0] <= mv_slot;
      for (int i = 1; i < DEPTH; i++)
        if (PW'(i) <= mv_pos) order[i] <= order[i-1];
      if (!hit_any && !full) fill_cnt <= fill_cnt + TW'(1);
      cur_tag     <= 3'(mv_slot);
      lookup_hit  <= hit_any;
      purge_valid <= !hit_any && full;
      purge_tag   <= (!hit_any && full) ? 3'(mv_slot) : 3'd0;
    end else begin
      lookup_hit  <= 1'b0;
      purge_valid <= 1'b0;
      purge_tag   <= 3'd0;
    end
  end

  always_ff @(posedge clk)
    if (rst_n && switch_valid && !hit_any) org[mv_slot - TW'(1)] <= switch_origin;

  // R2
  tag_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    switch_valid |=> cur_tag != 3'd0);
  // R7
  tag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !switch_valid |=> $stable(cur_tag));
  // R6
  purge_reuse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    purge_valid |-> (purge_tag == cur_tag && purge_tag != 3'd0));
  // R3
  no_early_purge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (switch_valid && !full) |=> !purge_valid);
  // R4
  hit_no_purge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lookup_hit |-> !purge_valid);
  // R8
  pulse_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !switch_valid |=> (!purge_valid && !lookup_hit && purge_tag == 3'd0));
  // R5
  head_chk: assert property (@(posedge clk) disable iff (!rst_n)
    switch_valid |=> order[0] == TW'(cur_tag));
endmodule

// File: tb/tb_asid_tag_stack.sv
module tb_asid_tag_stack;
  logic clk = 0, rst_n = 0, switch_valid = 0;
  logic [23:0] switch_origin = '0;
  logic [2:0] cur_tag, purge_tag;
  logic lookup_hit, purge_valid;
  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  asid_tag_stack dut (.clk(clk), .rst_n(rst_n), .switch_valid(switch_valid),
    .switch_origin(switch_origin), .cur_tag(cur_tag), .lookup_hit(lookup_hit),
    .purge_valid(purge_valid), .purge_tag(purge_tag));

  // {origin, tag, hit, purge, purge_tag}
  localparam logic [31:0] VEC [16] = '{
    {24'h000100, 3'd1, 1'b0, 1'b0, 3'd0},
    {24'h000200, 3'd2, 1'b0, 1'b0, 3'd0},
    {24'h000300, 3'd3, 1'b0, 1'b0, 3'd0},
    {24'h000400, 3'd4, 1'b0, 1'b0, 3'd0},
    {24'h000500, 3'd5, 1'b0, 1'b0, 3'd0},
    {24'h000600, 3'd6, 1'b0, 1'b0, 3'd0},
    {24'h000700, 3'd7, 1'b0, 1'b0, 3'd0},
    {24'h000300, 3'd3, 1'b1, 1'b0, 3'd0},
    {24'h000800, 3'd1, 1'b0, 1'b1, 3'd1},
    {24'h000200, 3'd2, 1'b1, 1'b0, 3'd0},
    {24'h000900, 3'd4, 1'b0, 1'b1, 3'd4},
    {24'h000100, 3'd5, 1'b0, 1'b1, 3'd5},
    {24'h000800, 3'd1, 1'b1, 1'b0, 3'd0},
    {24'h000A00, 3'd6, 1'b0, 1'b1, 3'd6},
    {24'h000400, 3'd7, 1'b0, 1'b1, 3'd7},
    {24'h000900, 3'd4, 1'b1, 1'b0, 3'd0}
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic chk_out(input string req, input logic [2:0] t, input logic h,
                         input logic p, input logic [2:0] pt);
    chk(req, {cur_tag, lookup_hit, purge_valid, purge_tag}, {t, h, p, pt});
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk_out("R1 in reset", 3'd0, 1'b0, 1'b0, 3'd0);
    rst_n = 1;
    @(negedge clk);
    chk_out("R1 after reset", 3'd0, 1'b0, 1'b0, 3'd0);

    // back-to-back table walk, one switch per cycle (R9); R3 R4 R5 R6
    for (int i = 0; i < 16; i++) begin
      switch_valid = 1;
      switch_origin = VEC[i][31:8];
      @(negedge clk);
      chk_out($sformatf("R3/R4/R5/R6/R9 vec %0d", i), VEC[i][7:5], VEC[i][4], VEC[i][3], VEC[i][2:0]);
      chk("R2 nonzero tag", {7'd0, cur_tag != 3'd0}, 8'd1);
    end

    // idle: tag held, pulses gone (R7, R8)
    switch_valid = 0;
    switch_origin = 24'h000B00;
    @(negedge clk);
    chk_out("R8 idle after hit", 3'd4, 1'b0, 1'b0, 3'd0);
    repeat (3) @(negedge clk);
    chk_out("R7 tag held idle", 3'd4, 1'b0, 1'b0, 3'd0);

    // evict then idle: purge is a single pulse (R8)
    switch_valid = 1; switch_origin = 24'h000C00;
    @(negedge clk);
    chk_out("R6 evict LRU", 3'd3, 1'b0, 1'b1, 3'd3);
    switch_valid = 0;
    @(negedge clk);
    chk_out("R8 purge one cycle", 3'd3, 1'b0, 1'b0, 3'd0);

    // reset mid-run, refill restarts at tag 1 (R1, R3)
    rst_n = 0;
    @(negedge clk);
    chk_out("R1 re-reset", 3'd0, 1'b0, 1'b0, 3'd0);
    rst_n = 1;
    switch_valid = 1; switch_origin = 24'h000C00;
    @(negedge clk);
    chk_out("R3 refill after reset", 3'd1, 1'b0, 1'b0, 3'd0);
    switch_origin = 24'h000C00;
    @(negedge clk);
    chk_out("R4 repeat hit", 3'd1, 1'b1, 1'b0, 3'd0);
    switch_valid = 0;
    @(negedge clk);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule